// File: doc/BRIEF.md
# Radix-2 Delay-Feedback FFT Stage with Per-Stage Wordlength

This block is one stage of a pipelined decimation-in-frequency FFT. It accepts one complex sample per clock, qualified by a valid strobe, and handles butterflies whose two inputs are half a span apart. Each sample in the first half of a span is parked in a feedback delay line. When its partner arrives in the second half, the stage emits the halved sum at once. It sends the halved difference through a twiddle rotation and writes the result back into the same delay-line slot. That slot is drained while the next span fills the line.

The input and output widths are independent parameters, so a chain of these stages can narrow or widen its data from one stage to the next. Every quantisation step is an arithmetic right shift, which is a floor. Products that could exceed full scale are clipped. Twiddles of 1 and -j never reach the multiplier. A local binary counter sequences the stage, and it advances only on valid samples. Up to the block's own arithmetic, chaining log2(N) stages with spans N, N/2, ..., 2 yields the N-point transform scaled by 1/N, in bit-reversed order.

Top module: `sdf_r2_stage`

## Requirements
- R1: Synchronous reset clears the sequencing counter and the output valid. After reset, out_valid stays low until SPAN/2 valid samples have been taken. It first rises in the cycle after the (SPAN/2+1)-th valid sample.
- R2: Within every group of SPAN valid samples, samples 0..D-1 (D = SPAN/2) are stored. During samples D..2D-1, the sums for butterflies m = 0..D-1 are output. During the first D samples of the next group, the stored rotated differences for m = 0..D-1 are output. A chain of stages with spans N, N/2, ..., 2 therefore delivers results in in-place (bit-reversed) order.
- R3: Each part of the sum output equals (a + b) arithmetically shifted right by IN_W+1-OUT_W bits, or shifted left if that amount is negative. Here a is the stored sample and b is the arriving sample, both IN_W-bit signed fractions.
- R4: The twiddle for butterfly m is exp(-j·2πm/SPAN). Its cosine and negated sine are each quantised to TW_W-bit signed values with TW_W-1 fraction bits. Rounding is to nearest with halves away from zero, and the result is clipped at 2^(TW_W-1)-1.
- R5: For a general m, with d = a - b and coefficient (c, s): re = T(d_re·c) - T(d_im·s) and im = T(d_re·s) + T(d_im·c). T is an arithmetic right shift by IN_W+TW_W-OUT_W applied to each product on its own. Each sum is then clipped to the signed OUT_W range.
- R6: For m = 0, the difference is output with only the R3 shift. For m = D/2 (when D ≥ 2), the output is re = shift(d_im) and im = shift(-d_re), exact up to the R3 shift.
- R7: The counter does not move on cycles without in_valid, so idle cycles change neither values nor order. Once primed, out_valid is high exactly in the cycle after each valid input.
- R8: Four chained stages for N = 16 produce, at output position p, the DFT bin bitrev(p) scaled by 1/16, within 0.015 of full scale per part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample qualifier |
| in_re | input | IN_W | Input real part, signed fraction |
| in_im | input | IN_W | Input imaginary part, signed fraction |
| out_valid | output | 1 | Output sample qualifier |
| out_re | output | OUT_W | Output real part, signed fraction |
| out_im | output | OUT_W | Output imaginary part, signed fraction |

## Verification
The bench feeds a four-stage chain with an impulse, DC, a tone, alternating signs, pseudo-random data and a ramp. It compares the first stage and the chain bit-for-bit against an in-place integer model. A design that rounded instead of flooring, or truncated after adding the partial products, would be off by one LSB on rotated outputs. A full-scale block with opposite halves drives the rotated difference past full scale, so a missing clip would wrap the sign. A swapped sign on the -j bypass corrupts the m = D/2 slots. The whole table is then replayed with idle cycles inserted, and a counter that stepped on idle cycles would scramble the order. A reset applied mid-stream checks that no stale output is flagged valid before the delay line has refilled.

// File: rtl/sdf_r2_stage.sv
module sdf_r2_stage #(
  parameter int SPAN  = 16,
  parameter int IN_W  = 12,
  parameter int OUT_W = 12,
  parameter int TW_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_re,
  input  logic signed [IN_W-1:0]  in_im,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_re,
  output logic signed [OUT_W-1:0] out_im
);
  localparam int D    = SPAN / 2;
  localparam int CW   = $clog2(SPAN);
  localparam int AW   = (CW > 1) ? CW - 1 : 1;
  localparam int DA   = 1 << AW;
  localparam int MW   = (IN_W > OUT_W) ? IN_W : OUT_W;
  localparam int EW   = IN_W + TW_W + OUT_W + 4;
  localparam int SS   = IN_W + 1 - OUT_W;
  localparam int PS   = IN_W + TW_W - OUT_W;
  localparam int SS_R = (SS > 0) ? SS : 0;
  localparam int SS_L = (SS < 0) ? -SS : 0;
  localparam int PS_R = (PS > 0) ? PS : 0;
  localparam int PS_L = (PS < 0) ? -PS : 0;
  localparam logic signed [EW-1:0] HI = EW'(2 ** (OUT_W - 1) - 1);
  localparam logic signed [EW-1:0] LO = -HI - EW'(1);

  function automatic int qcoef(input real x);
    real r;
    int  q;
    r = x * real'(2 ** (TW_W - 1));
    q = (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(0.5 - r);
    if (q > 2 ** (TW_W - 1) - 1) q = 2 ** (TW_W - 1) - 1;
    return q;
  endfunction

  function automatic logic signed [OUT_W-1:0] clip(input logic signed [EW-1:0] v);
    if (v > HI) return OUT_W'(HI);
    if (v < LO) return OUT_W'(LO);
    return OUT_W'(v);
  endfunction

  function automatic logic signed [EW-1:0] sh_s(input logic signed [EW-1:0] v);
    return (v <<< SS_L) >>> SS_R;
  endfunction

  function automatic logic signed [EW-1:0] sh_p(input logic signed [EW-1:0] v);
    return (v <<< PS_L) >>> PS_R;
  endfunction

  logic signed [TW_W-1:0] tw_c [DA];
  logic signed [TW_W-1:0] tw_s [DA];
  for (genvar m = 0; m < DA; m++) begin : g_tw
    localparam real ANG = 6.283185307179586 * real'(m) / real'(SPAN);
    localparam int  QC  = qcoef($cos(ANG));
    localparam int  QS  = qcoef(-$sin(ANG));
    assign tw_c[m] = TW_W'(QC);
    assign tw_s[m] = TW_W'(QS);
  end

  logic [CW-1:0] cnt;
  logic          primed;
  logic          phase;
  logic [AW-1:0] addr;
  assign phase = cnt[CW-1];
  assign addr  = AW'(cnt) & AW'(D - 1);

  logic signed [MW-1:0] dl_re [DA];
  logic signed [MW-1:0] dl_im [DA];
  logic signed [MW-1:0] rd_re, rd_im;
  assign rd_re = dl_re[addr];
  assign rd_im = dl_im[addr];

  logic signed [EW-1:0] a_re, a_im, b_re, b_im, d_re, d_im, wc, ws;
  assign a_re = EW'($signed(rd_re[IN_W-1:0]));
  assign a_im = EW'($signed(rd_im[IN_W-1:0]));
  assign b_re = EW'(in_re);
  assign b_im = EW'(in_im);
  assign d_re = a_re - b_re;
  assign d_im = a_im - b_im;
  assign wc   = EW'(tw_c[addr]);
  assign ws   = EW'(tw_s[addr]);

  logic signed [OUT_W-1:0] sum_re, sum_im, rot_re, rot_im;
  assign sum_re = clip(sh_s(a_re + b_re));
  assign sum_im = clip(sh_s(a_im + b_im));

  always_comb begin
    if (addr == '0) begin
      rot_re = clip(sh_s(d_re));
      rot_im = clip(sh_s(d_im));
    end else if (D >= 2 && addr == AW'(D / 2)) begin
      rot_re = clip(sh_s(d_im));
      rot_im = clip(sh_s(-d_re));
    end else begin
      rot_re = clip(sh_p(d_re * wc) - sh_p(d_im * ws));
      rot_im = clip(sh_p(d_re * ws) + sh_p(d_im * wc));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      primed    <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid & (primed | phase);
      if (in_valid) begin
        cnt <= cnt + 1'b1;
        if (phase) primed <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      if (phase) begin
        dl_re[addr] <= MW'(rot_re);
        dl_im[addr] <= MW'(rot_im);
        out_re      <= sum_re;
        out_im      <= sum_im;
      end else begin
        dl_re[addr] <= MW'(in_re);
        dl_im[addr] <= MW'(in_im);
        out_re      <= $signed(rd_re[OUT_W-1:0]);
        out_im      <= $signed(rd_im[OUT_W-1:0]);
      end
    end
  end

  AST_CLEAR_AFTER_RESET: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> !out_valid); // R1
  AST_SUM_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst) (in_valid && phase) |=> out_valid); // R2
  AST_CNT_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(cnt)); // R7
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst) (in_valid && cnt == '1) |=> cnt == '0); // R2
  AST_OUT_FOLLOWS_IN: assert property (@(posedge clk) disable iff (rst) out_valid |-> $past(in_valid)); // R7
endmodule

// File: tb/test_sdf_r2_stage.sv
module test_sdf_r2_stage;
  localparam int N    = 16;
  localparam int IW   = 12;
  localparam int W1   = 13;
  localparam int W2   = 12;
  localparam int W3   = 11;
  localparam int W4   = 10;
  localparam int TW   = 10;
  localparam int NPAT = 7;
  localparam int NS   = (NPAT + 1) * N;
  localparam int PAT_KIND [NPAT] = '{0, 1, 2, 3, 4, 5, 6};
  localparam int PAT_AMP  [NPAT] = '{1500, 700, 1400, 1000, 1400, 0, 1200};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vin = 1'b0;
  logic signed [IW-1:0] xr = '0, xi = '0;
  logic v1, v2, v3, v4;
  logic signed [W1-1:0] r1, i1;
  logic signed [W2-1:0] r2, i2;
  logic signed [W3-1:0] r3, i3;
  logic signed [W4-1:0] r4, i4;

  always #4 clk = ~clk;

  sdf_r2_stage #(.SPAN(16), .IN_W(IW), .OUT_W(W1), .TW_W(TW)) i_sdf_r2_stage (
    .clk(clk), .rst(rst), .in_valid(vin), .in_re(xr), .in_im(xi),
    .out_valid(v1), .out_re(r1), .out_im(i1));
  sdf_r2_stage #(.SPAN(8), .IN_W(W1), .OUT_W(W2), .TW_W(TW)) i_st2 (
    .clk(clk), .rst(rst), .in_valid(v1), .in_re(r1), .in_im(i1),
    .out_valid(v2), .out_re(r2), .out_im(i2));
  sdf_r2_stage #(.SPAN(4), .IN_W(W2), .OUT_W(W3), .TW_W(TW)) i_st3 (
    .clk(clk), .rst(rst), .in_valid(v2), .in_re(r2), .in_im(i2),
    .out_valid(v3), .out_re(r3), .out_im(i3));
  sdf_r2_stage #(.SPAN(2), .IN_W(W3), .OUT_W(W4), .TW_W(TW)) i_st4 (
    .clk(clk), .rst(rst), .in_valid(v3), .in_re(r3), .in_im(i3),
    .out_valid(v4), .out_re(r4), .out_im(i4));

  int nchk = 0, nfail = 0, nin = 0, n1 = 0, n4 = 0, first_at = -1;
  bit done = 0;
  int c1_re [NS], c1_im [NS], c4_re [NS], c4_im [NS];
  int mre [N], mim [N], xin_re [N], xin_im [N];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int shf(input int v, input int s);
    return (s >= 0) ? (v >>> s) : (v <<< (-s));
  endfunction

  function automatic int sat(input int v, input int w);
    int hi = (1 <<< (w - 1)) - 1;
    if (v > hi) return hi;
    if (v < -hi - 1) return -hi - 1;
    return v;
  endfunction

  function automatic int qco(input real x);
    real r = x * real'(1 <<< (TW - 1));
    int q = (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(0.5 - r);
    if (q > (1 <<< (TW - 1)) - 1) q = (1 <<< (TW - 1)) - 1;
    return q;
  endfunction

  task automatic model_stage(input int L, input int iw, input int ow);
    for (int g = 0; g < N; g += L) begin
      for (int m = 0; m < L / 2; m++) begin
        int a = g + m, b = g + m + L / 2;
        int dr = mre[a] - mre[b], di = mim[a] - mim[b];
        int ss = iw + 1 - ow, ps = iw + TW - ow;
        mre[a] = shf(mre[a] + mre[b], ss);
        mim[a] = shf(mim[a] + mim[b], ss);
        if (m == 0) begin
          mre[b] = shf(dr, ss); mim[b] = shf(di, ss);
        end else if (L >= 4 && m == L / 4) begin
          mre[b] = shf(di, ss); mim[b] = shf(-dr, ss);
        end else begin
          real ang = 6.283185307179586 * real'(m) / real'(L);
          int c = qco($cos(ang)), s = qco(-$sin(ang));
          mre[b] = sat(shf(dr * c, ps) - shf(di * s, ps), ow);
          mim[b] = sat(shf(dr * s, ps) + shf(di * c, ps), ow);
        end
      end
    end
  endtask

  function automatic int samp(input int b, input int n, input bit im);
    int k = PAT_KIND[b], a = PAT_AMP[b];
    real ang = 6.283185307179586 * 3.0 * real'(n) / 16.0;
    case (k)
      0: return (n == 0 && !im) ? a : 0;
      1: return im ? -a / 2 : a;
      2: return $rtoi((im ? $sin(ang) : $cos(ang)) * real'(a));
      3: return im ? ((n % 4 < 2) ? a : -a) : ((n % 2 == 1) ? -a : a);
      4: return (((n * 73 + (im ? 151 : 0) + 29) % 97) - 48) * a / 48;
      5: return (n < 8) ? 2047 : -2048;
      default: return im ? (8 - n) * a / 16 : (n - 8) * a / 8;
    endcase
  endfunction

  task automatic drive(input logic v, input int re, input int im);
    @(negedge clk);
    vin = v; xr = IW'(re); xi = IW'(im);
    if (v) nin++;
  endtask

  always @(posedge clk) begin
    #2;
    if (!rst) begin
      if (v1 && first_at < 0) first_at = nin;
      if (v1 && n1 < NS) begin c1_re[n1] = int'(r1); c1_im[n1] = int'(i1); n1++; end
      if (v4 && n4 < NS) begin c4_re[n4] = int'(r4); c4_im[n4] = int'(i4); n4++; end
    end
  end

  task automatic run_pass(input bit gaps);
    string pre = gaps ? "R7 idle-gaps " : "";
    @(negedge clk); rst = 1; vin = 0;
    repeat (3) @(negedge clk);
    nin = 0; n1 = 0; n4 = 0; first_at = -1;
    rst = 0;
    @(negedge clk);
    chk(v1 == 0 && v4 == 0, {pre, "R1 valid low after reset"}, int'(v1) + int'(v4), 0);
    for (int b = 0; b <= NPAT; b++) begin
      for (int n = 0; n < N; n++) begin
        drive(1, (b < NPAT) ? samp(b, n, 0) : 0, (b < NPAT) ? samp(b, n, 1) : 0);
        if (gaps && (n % 3 == 1)) drive(0, 0, 0);
      end
    end
    drive(0, 0, 0);
    repeat (30) @(negedge clk);
    chk(first_at == N / 2 + 1, {pre, "R1 first valid after D+1 inputs"}, first_at, N / 2 + 1);
    chk(n1 == NS - N / 2, {pre, "R7 stage output count"}, n1, NS - N / 2);
    for (int b = 0; b < NPAT; b++) begin
      for (int n = 0; n < N; n++) begin
        xin_re[n] = samp(b, n, 0); xin_im[n] = samp(b, n, 1);
        mre[n] = xin_re[n]; mim[n] = xin_im[n];
      end
      model_stage(16, IW, W1);
      for (int p = 0; p < N; p++) begin
        string tag = (p < 8) ? "R3 sum" : ((p == 8 || p == 12) ? "R6 trivial twiddle" : "R5 rotate (R4 coef)");
        chk(c1_re[b * N + p] == mre[p], {pre, tag, " re"}, c1_re[b * N + p], mre[p]);
        chk(c1_im[b * N + p] == mim[p], {pre, tag, " im"}, c1_im[b * N + p], mim[p]);
      end
      model_stage(8, W1, W2);
      model_stage(4, W2, W3);
      model_stage(2, W3, W4);
      for (int p = 0; p < N; p++) begin
        chk(c4_re[b * N + p] == mre[p], {pre, "R2 chain order re"}, c4_re[b * N + p], mre[p]);
        chk(c4_im[b * N + p] == mim[p], {pre, "R2 chain order im"}, c4_im[b * N + p], mim[p]);
      end
      if (PAT_KIND[b] != 5) begin
        for (int p = 0; p < N; p++) begin
          int k = {p[0], p[1], p[2], p[3]};
          real sr = 0.0, si = 0.0, er, ei, ar, ai;
          for (int n = 0; n < N; n++) begin
            real ang = -6.283185307179586 * real'(k * n) / 16.0;
            sr += real'(xin_re[n]) * $cos(ang) - real'(xin_im[n]) * $sin(ang);
            si += real'(xin_re[n]) * $sin(ang) + real'(xin_im[n]) * $cos(ang);
          end
          er = sr / 16.0 / 2048.0; ei = si / 16.0 / 2048.0;
          ar = real'(c4_re[b * N + p]) / 512.0; ai = real'(c4_im[b * N + p]) / 512.0;
          chk((ar - er) < 0.015 && (er - ar) < 0.015, {pre, "R8 DFT re x1e4"}, $rtoi(ar * 1e4), $rtoi(er * 1e4));
          chk((ai - ei) < 0.015 && (ei - ai) < 0.015, {pre, "R8 DFT im x1e4"}, $rtoi(ai * 1e4), $rtoi(ei * 1e4));
        end
      end
    end
  endtask

  initial begin
    run_pass(0);
    run_pass(1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule